// File: doc/BRIEF.md
# Gated Prescaled Period Timer

This block is a 16-bit up-counter with its own period register. Each time the counter advances while it already holds the period value, it returns to zero and raises a sticky interrupt flag. The counter advances on prescaled ticks. A tick is one of three things, depending on the mode: every system clock cycle, each rising edge of an external clock pin, or each system clock cycle in which an external gate input is high.

The external clock pin can pass through a two-flop synchroniser before edge detection, or it can skip that synchroniser so its edges are counted with less delay. In gated mode the count accumulates the time the gate stays high. The flag is then raised on the gate's falling edge and not on a period match.

Software uses a single write port with a 2-bit address. The port loads the count, loads the period, sets the control fields and clears the flag. The current count and the flag are visible as outputs.

Top module: `gate_period_timer`

## Requirements
- R1: After reset, count_o is 0, irq_flag_o is 0, and every control field is 0, so the timer is stopped.
- R2: A write to address 0 loads the count. A write to address 1 loads the period. A write to address 2 loads the control word: bit0 run, bits[2:1] prescale select, bit3 external source, bit4 external synchronise, bit5 gate mode. A write to address 3 with bit0 set clears the flag. A count load takes priority over counting in the same cycle.
- R3: While running, each prescaler output step increments the count. A step that finds the count equal to the period sets the count to 0 and sets the flag. With the internal source and no gating, a period value P with ratio N gives exactly (P+1)*N cycles between flag events.
- R4: Prescale select 00 gives a ratio of 1, 01 gives 8, 10 gives 64 and 11 gives 256.
- R5: The prescaler phase returns to zero on any count write and whenever run is 0. After a count write with ratio 8, the count stays unchanged for 7 cycles and advances on the 8th.
- R6: With the external source selected, each rising edge of ext_clk_i counts once. With synchronise set, the increment appears on the third clk_i rising edge after ext_clk_i goes high. With synchronise clear, it appears on the first such edge.
- R7: Gate mode with the internal source and a ratio of 1 adds exactly one count per clk_i cycle that gate_i is high. It sets the flag within 5 cycles of the gate's falling edge. A period wrap in this mode resets the count but does not set the flag.
- R8: When the external source is selected, the gate mode bit has no effect: gate_i neither counts nor sets the flag.
- R9: While run is 0, the count holds its value unless it is written.
- R10: The flag stays set until it is cleared through address 3. If a set event and a clear happen in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; also the internal count source |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ext_clk_i | input | 1 | External clock pin |
| gate_i | input | 1 | External gate level |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select: 0 count, 1 period, 2 control, 3 flag clear |
| wr_data_i | input | 16 | Write data |
| count_o | output | 16 | Current count |
| irq_flag_o | output | 1 | Sticky interrupt flag |

## Verification
The hardest situation to reach from the ports is a flag set and a flag clear landing in the same clock cycle. The stimulus sets the period to zero with a ratio of 1, so a match event occurs on every cycle, and any clear write is then guaranteed to collide with a set. A second hard case is a count write that arrives in the middle of a prescaler phase. The bench lets a ratio-8 prescaler run for a few cycles, writes the count, and counts the cycles exactly until the next increment. The timing difference between synchronised and direct external counting is checked by raising the pin at a falling clock edge and sampling the count one, two and three edges later.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

   typedef enum logic [1:0] {
      ADDR_COUNT  = 2'd0,
      ADDR_PERIOD = 2'd1,
      ADDR_CTRL   = 2'd2,
      ADDR_CLEAR  = 2'd3
   } gpt_addr_e;

   // Control word, bit0 is run
   typedef struct packed {
      logic       gate_mode;
      logic       ext_sync;
      logic       ext_src;
      logic [1:0] ps_sel;
      logic       run;
   } gpt_ctrl_t;

   localparam int unsigned CTRL_W = $bits(gpt_ctrl_t);

endpackage

// File: rtl/gpt_sync.sv
module gpt_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 1) begin : g_bad_stages
      $error("gpt_sync: STAGES must be at least 1");
   end

   logic [STAGES-1:0] chain_q;

   if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) chain_q <= '0;
         else         chain_q <= d_i;
      end
   end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) chain_q <= '0;
         else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpt_input_cond.sv
module gpt_input_cond #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic ext_clk_i,
   input  logic gate_i,
   input  logic ext_sync_i,
   output logic ext_rise_o,
   output logic gate_level_o,
   output logic gate_fall_o
);
   logic ext_s, ext_cur, ext_prev_q;
   logic gate_s, gate_prev_q;

   gpt_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (ext_clk_i),
      .q_o   (ext_s)
   );

   gpt_sync #(.STAGES(SYNC_STAGES)) u_gate_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (gate_i),
      .q_o   (gate_s)
   );

   // Direct path skips the synchroniser; edge detect stays in clk_i domain
   assign ext_cur = ext_sync_i ? ext_s : ext_clk_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ext_prev_q  <= 1'b0;
         gate_prev_q <= 1'b0;
      end else begin
         ext_prev_q  <= ext_cur;
         gate_prev_q <= gate_s;
      end
   end

   assign ext_rise_o   = ext_cur & ~ext_prev_q;
   assign gate_level_o = gate_s;
   assign gate_fall_o  = gate_prev_q & ~gate_s;
endmodule

// File: rtl/gpt_prescaler.sv
module gpt_prescaler #(
   parameter int unsigned SH1 = 3,
   parameter int unsigned SH2 = 6,
   parameter int unsigned SH3 = 8
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       clear_i,
   input  logic       tick_i,
   input  logic [1:0] sel_i,
   output logic       step_o
);
   localparam int unsigned PRE_W = SH3;

   if (!(SH1 > 0 && SH1 < SH2 && SH2 < SH3)) begin : g_bad_shifts
      $error("gpt_prescaler: shifts must be strictly increasing and non-zero");
   end

   logic [PRE_W-1:0] phase_q;
   logic [PRE_W-1:0] term;
   logic [PRE_W:0]   term_full;
   int unsigned      sh;

   always_comb begin
      unique case (sel_i)
         2'd0:    sh = 0;
         2'd1:    sh = SH1;
         2'd2:    sh = SH2;
         default: sh = SH3;
      endcase
      term_full = ({{PRE_W{1'b0}}, 1'b1} << sh) - 1'b1;
      term      = term_full[PRE_W-1:0];
   end

   assign step_o = tick_i & (phase_q == term);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      phase_q <= '0;
      else if (clear_i) phase_q <= '0;
      else if (tick_i)  phase_q <= (phase_q == term) ? '0 : phase_q + 1'b1;
   end
endmodule

// File: rtl/gate_period_timer.sv
module gate_period_timer
   import gpt_pkg::*;
#(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned PS_SH1      = 3,
   parameter int unsigned PS_SH2      = 6,
   parameter int unsigned PS_SH3      = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             ext_clk_i,
   input  logic             gate_i,
   input  logic             wr_en_i,
   input  logic [1:0]       wr_addr_i,
   input  logic [CNT_W-1:0] wr_data_i,
   output logic [CNT_W-1:0] count_o,
   output logic             irq_flag_o
);
   if (CNT_W < CTRL_W) begin : g_bad_width
      $error("gate_period_timer: CNT_W too narrow for the control word");
   end

   gpt_ctrl_t        ctrl_q;
   logic [CNT_W-1:0] count_q, period_q;
   logic             flag_q;
   logic             wr_count, wr_period, wr_ctrl, flag_clr;
   logic             ext_rise, gate_level, gate_fall;
   logic             gate_act, tick, step, presc_clear, at_period, flag_set;

   assign wr_count  = wr_en_i && (wr_addr_i == ADDR_COUNT);
   assign wr_period = wr_en_i && (wr_addr_i == ADDR_PERIOD);
   assign wr_ctrl   = wr_en_i && (wr_addr_i == ADDR_CTRL);
   assign flag_clr  = wr_en_i && (wr_addr_i == ADDR_CLEAR) && wr_data_i[0];

   gpt_input_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .ext_clk_i   (ext_clk_i),
      .gate_i      (gate_i),
      .ext_sync_i  (ctrl_q.ext_sync),
      .ext_rise_o  (ext_rise),
      .gate_level_o(gate_level),
      .gate_fall_o (gate_fall)
   );

   // Gate only applies to the internal source
   assign gate_act = ctrl_q.gate_mode & ~ctrl_q.ext_src;

   always_comb begin
      if (ctrl_q.ext_src) tick = ext_rise;
      else if (gate_act)  tick = gate_level;
      else                tick = 1'b1;
   end

   assign presc_clear = wr_count | ~ctrl_q.run;

   gpt_prescaler #(.SH1(PS_SH1), .SH2(PS_SH2), .SH3(PS_SH3)) u_presc (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clear_i(presc_clear),
      .tick_i (tick),
      .sel_i  (ctrl_q.ps_sel),
      .step_o (step)
   );

   assign at_period = (count_q == period_q);

   assign flag_set = ctrl_q.run &
                     ((~gate_act & step & at_period & ~wr_count) |
                      (gate_act & gate_fall));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ctrl_q   <= '0;
         period_q <= '0;
      end else begin
         if (wr_ctrl)   ctrl_q   <= gpt_ctrl_t'(wr_data_i[CTRL_W-1:0]);
         if (wr_period) period_q <= wr_data_i;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  count_q <= '0;
      else if (wr_count)            count_q <= wr_data_i;
      else if (ctrl_q.run && step)  count_q <= at_period ? '0 : count_q + 1'b1;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_q <= 1'b0;
      else if (flag_set) flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
   end

   assign count_o    = count_q;
   assign irq_flag_o = flag_q;
endmodule

// File: rtl/gpt_checker.sv
module gpt_checker #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             run,
   input logic             step,
   input logic             at_period,
   input logic             wr_count,
   input logic [CNT_W-1:0] wr_data,
   input logic [CNT_W-1:0] count,
   input logic             flag_set,
   input logic             flag_clr,
   input logic             flag
);
   // R2: count load takes effect next cycle
   a_r2_count_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_count |=> count == $past(wr_data));

   // R3: match step wraps to zero
   a_r3_wrap_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run && step && at_period && !wr_count) |=> count == '0);

   // R3: non-match step advances by one
   a_r3_count_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run && step && !at_period && !wr_count) |=> count == CNT_W'($past(count) + 1'b1));

   // R9: stopped timer holds
   a_r9_hold_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run && !wr_count) |=> $stable(count));

   // R10: flag sticky without clear
   a_r10_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag && !flag_clr) |=> flag);

   // R10: set beats clear
   a_r10_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flag_set |=> flag);

   // R10: clear alone drops the flag
   a_r10_clear_works: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_clr && !flag_set) |=> !flag);
endmodule

bind gate_period_timer gpt_checker #(.CNT_W(CNT_W)) u_chk (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .run      (ctrl_q.run),
   .step     (step),
   .at_period(at_period),
   .wr_count (wr_count),
   .wr_data  (wr_data_i),
   .count    (count_q),
   .flag_set (flag_set),
   .flag_clr (flag_clr),
   .flag     (irq_flag_o)
);

// File: tb/gate_period_timer_tb_top.sv
module gate_period_timer_tb_top;
   logic        clk_i = 1'b0;
   logic        rst_ni = 1'b0;
   logic        ext_clk_i = 1'b0;
   logic        gate_i = 1'b0;
   logic        wr_en_i = 1'b0;
   logic [1:0]  wr_addr_i = '0;
   logic [15:0] wr_data_i = '0;
   logic [15:0] count_o;
   logic        irq_flag_o;

   int n_cmp = 0;
   int n_bad = 0;
   longint cyc = 0;

   localparam logic [15:0] RUN  = 16'h0001;
   localparam logic [15:0] EXT  = 16'h0008;
   localparam logic [15:0] SYNC = 16'h0010;
   localparam logic [15:0] GATE = 16'h0020;

   always #5 clk_i = ~clk_i;
   always @(posedge clk_i) cyc <= cyc + 1;

   gate_period_timer dut_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ext_clk_i (ext_clk_i),
      .gate_i    (gate_i),
      .wr_en_i   (wr_en_i),
      .wr_addr_i (wr_addr_i),
      .wr_data_i (wr_data_i),
      .count_o   (count_o),
      .irq_flag_o(irq_flag_o)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk_i);
      wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
      @(negedge clk_i);
      wr_en_i = 1'b0;
   endtask

   task automatic setup(input logic [15:0] cnt, input logic [15:0] per);
      wr(2'd2, 16'h0000);
      wr(2'd0, cnt);
      wr(2'd1, per);
      wr(2'd3, 16'h0001);
   endtask

   task automatic wait_flag(input string req, output longint t);
      int n = 0;
      while (!irq_flag_o && n < 5000) begin
         @(negedge clk_i);
         n++;
      end
      if (!irq_flag_o) begin
         n_cmp++; n_bad++;
         $display("FAIL %s flag wait: actual 0 expected 1", req);
      end
      t = cyc;
   endtask

   task automatic t_reset();
      chk("R1", "reset count", count_o, 0);
      chk("R1", "reset flag", irq_flag_o, 0);
      repeat (4) @(negedge clk_i);
      chk("R1", "stopped after reset", count_o, 0);
   endtask

   task automatic t_load_hold();
      wr(2'd0, 16'h1234);
      chk("R2", "count load", count_o, 16'h1234);
      wr(2'd2, RUN);
      repeat (3) @(negedge clk_i);
      wr(2'd2, 16'h0000);
      begin
         logic [15:0] v = count_o;
         repeat (10) @(negedge clk_i);
         chk("R9", "hold when stopped", count_o, v);
      end
   endtask

   task automatic t_period(input int ps, input int per);
      longint t0, t1;
      int ratio = (ps == 0) ? 1 : (ps == 1) ? 8 : (ps == 2) ? 64 : 256;
      setup(16'd0, 16'(per));
      wr(2'd2, RUN | 16'(ps << 1));
      wait_flag("R3", t0);
      wr(2'd3, 16'h0001);
      chk("R10", "clear drops flag", irq_flag_o, 0);
      wait_flag("R4", t1);
      chk("R4", $sformatf("interval ps=%0d P=%0d", ps, per), 32'(t1 - t0),
          32'((per + 1) * ratio));
      wr(2'd2, 16'h0000);
   endtask

   task automatic t_presc_clear();
      setup(16'd0, 16'hFFFF);
      wr(2'd2, RUN | 16'h0002);
      repeat (5) @(negedge clk_i);
      wr(2'd0, 16'd100);
      chk("R5", "count after load", count_o, 100);
      repeat (7) @(negedge clk_i);
      chk("R5", "no step before 8 cycles", count_o, 100);
      @(negedge clk_i);
      chk("R5", "step on 8th cycle", count_o, 101);
      wr(2'd2, 16'h0000);
   endtask

   task automatic t_ext(input bit sync);
      setup(16'd0, 16'hFFFF);
      wr(2'd2, RUN | EXT | (sync ? SYNC : 16'h0));
      repeat (2) @(negedge clk_i);
      ext_clk_i = 1'b1;
      @(negedge clk_i);
      if (sync) begin
         chk("R6", "sync edge 1", count_o, 0);
         @(negedge clk_i);
         chk("R6", "sync edge 2", count_o, 0);
         @(negedge clk_i);
         chk("R6", "sync edge 3", count_o, 1);
      end else begin
         chk("R6", "direct edge 1", count_o, 1);
      end
      repeat (3) @(negedge clk_i);
      ext_clk_i = 1'b0;
      repeat (3) @(negedge clk_i);
      for (int k = 0; k < 5; k++) begin
         ext_clk_i = 1'b1;
         repeat (3) @(negedge clk_i);
         ext_clk_i = 1'b0;
         repeat (3) @(negedge clk_i);
      end
      repeat (4) @(negedge clk_i);
      chk("R6", sync ? "sync edge total" : "direct edge total", count_o, 6);
      wr(2'd2, 16'h0000);
   endtask

   task automatic t_gate();
      int acc = 0;
      setup(16'd0, 16'hFFFF);
      wr(2'd2, RUN | GATE);
      for (int k = 0; k < 5; k++) begin
         int w = 3 + int'($urandom % 40);
         gate_i = 1'b1;
         repeat (w) @(negedge clk_i);
         gate_i = 1'b0;
         chk("R7", "no flag while gate high", irq_flag_o, 0);
         repeat (5) @(negedge clk_i);
         acc += w;
         chk("R7", $sformatf("gated total w=%0d", w), count_o, 32'(acc));
         chk("R7", "flag on gate fall", irq_flag_o, 1);
         wr(2'd3, 16'h0001);
         repeat (2) @(negedge clk_i);
      end
      // wrap inside gate mode gives no flag
      setup(16'd0, 16'd5);
      wr(2'd2, RUN | GATE);
      gate_i = 1'b1;
      repeat (20) @(negedge clk_i);
      gate_i = 1'b0;
      chk("R7", "no flag on gated wrap", irq_flag_o, 0);
      repeat (5) @(negedge clk_i);
      chk("R7", "gated wrap count", count_o, 2);
      wr(2'd2, 16'h0000);
   endtask

   task automatic t_gate_ignored();
      setup(16'd0, 16'hFFFF);
      wr(2'd2, RUN | EXT | SYNC | GATE);
      gate_i = 1'b1;
      repeat (10) @(negedge clk_i);
      gate_i = 1'b0;
      repeat (6) @(negedge clk_i);
      chk("R8", "gate ignored count", count_o, 0);
      chk("R8", "gate ignored flag", irq_flag_o, 0);
      wr(2'd2, 16'h0000);
   endtask

   task automatic t_set_wins();
      setup(16'd0, 16'd0);
      wr(2'd2, RUN);
      repeat (3) @(negedge clk_i);
      wr(2'd3, 16'h0001);
      chk("R10", "set wins over clear", irq_flag_o, 1);
      wr(2'd2, 16'h0000);
      chk("R10", "sticky after stop", irq_flag_o, 1);
      wr(2'd3, 16'h0001);
      chk("R10", "clear when idle", irq_flag_o, 0);
   endtask

   initial begin
      #2_000_000;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk_i);
      rst_ni = 1'b1;
      @(negedge clk_i);
      t_reset();
      t_load_hold();
      t_period(0, 3);
      t_period(0, 9);
      t_period(1, 3);
      t_period(2, 3);
      t_period(3, 3);
      t_presc_clear();
      t_ext(1'b1);
      t_ext(1'b0);
      t_gate();
      t_gate_ignored();
      t_set_wins();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule